// File: doc/BRIEF.md
# Recirculating Parallel-Load Shift Register

This block is a word-wide shift register with one serial port that works in both directions, plus a parallel load from a data bus. The serial port writes bits into the register, and it also reads the word back out. A read is not destructive. The bit leaving the top of the register is fed back into the bottom, so after one full word of read clocks the register holds its starting value again. The serial port is modelled as three signals: an input, an output and an output enable. A pad ring outside the block can combine them into one three-state pin.

An active-low select gates every clock action. While the select is high, the register holds its value and the port stays undriven. Each cycle the select and the two-bit mode are decoded into one of four operations:

- `OP_IDLE` (hold, or deselected)
- `OP_WRITE` (serial entry)
- `OP_READ` (recirculating serial read)
- `OP_LOAD` (parallel capture)

Every cycle moves from the current operation to whichever operation the inputs present. There are no other states or transitions.

Top module: `recirc_shift_reg`

## Requirements
- R1: An asynchronous active-low reset clears every register bit to 0.
- R2: With `sel_n` low and `mode` = 2'b11, the rising clock edge copies `din` into the register, bit for bit.
- R3: With `sel_n` low and `mode` = 2'b10, `ser_oe` is 1 and `ser_out` shows register bit WIDTH-1 during the cycle. At the rising edge each bit moves up one position, and the old bit WIDTH-1 enters bit 0.
- R4: WIDTH consecutive read clocks leave the register exactly as it was before the first of them.
- R5: With `sel_n` low and `mode` = 2'b01, `ser_oe` is 0. At the rising edge each bit moves up one position and `ser_in` enters bit 0, so the first bit written ends in bit WIDTH-1 after WIDTH writes.
- R6: With `sel_n` low and `mode` = 2'b00, the register keeps its value whatever `ser_in` and `din` do, and `ser_oe` is 0.
- R7: With `sel_n` high, the register keeps its value for every `mode`, and `ser_oe` is 0.
- R8: Whenever `ser_oe` is 0, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations act on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Select, active low; high blocks clocking and idles the port |
| mode | input | 2 | 00 hold, 01 serial write, 10 serial read, 11 parallel load |
| din | input | WIDTH | Parallel load data |
| ser_in | input | 1 | Serial port input value |
| ser_out | output | 1 | Serial port output value |
| ser_oe | output | 1 | Serial port output enable |

## Verification
The bench builds the block with its default WIDTH of 16. At that width a full recirculation takes sixteen read clocks, which is short enough to run many times. Sixteen write clocks likewise replace a whole word.

Single-bit patterns such as 16'h8001 place ones at both ends of the word. Reading that pattern partially and then in full exposes the wrap from the top bit into bit 0. Short write bursts show that bits enter at the bottom and move up.

// File: rtl/recirc_pkg.sv
package recirc_pkg;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] MODE_HOLD  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_WRITE = 2'b01;
    localparam logic [MODE_W-1:0] MODE_READ  = 2'b10;
    localparam logic [MODE_W-1:0] MODE_LOAD  = 2'b11;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_LOAD  = 2'd3
    } op_e;

endpackage

// File: rtl/recirc_op_decode.sv
module recirc_op_decode
    import recirc_pkg::*;
(
    input  logic              sel_n,
    input  logic [MODE_W-1:0] mode,
    output op_e               op,
    output logic              port_oe
);

    // Operation select: a high select forces idle for every mode
    always_comb begin
        if (sel_n) begin
            op = OP_IDLE;
        end else begin
            unique case (mode)
                MODE_HOLD:  op = OP_IDLE;
                MODE_WRITE: op = OP_WRITE;
                MODE_READ:  op = OP_READ;
                MODE_LOAD:  op = OP_LOAD;
                default:    op = OP_IDLE;
            endcase
        end
    end

    // Port drive: only a recirculating read turns the port around
    always_comb begin
        unique case (op)
            OP_READ: port_oe = 1'b1;
            default: port_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/recirc_shift_core.sv
module recirc_shift_core
    import recirc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] din,
    output logic             top_bit
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] word_d;
    logic             fill_bit;

    // Bit entering position 0: the wrapped top bit on read, the port on write
    always_comb begin
        unique case (op)
            OP_READ: fill_bit = word_q[MSB];
            default: fill_bit = ser_in;
        endcase
    end

    // Per-bit next-value selection
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        if (i == 0) begin : g_bottom
            assign from_below = fill_bit;
        end else begin : g_upper
            assign from_below = word_q[i-1];
        end
        assign word_d[i] = (op == OP_LOAD)                      ? din[i]     :
                           (op == OP_WRITE || op == OP_READ)    ? from_below :
                                                                  word_q[i];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    always_comb top_bit = word_q[MSB];

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (word_q == $past(din)));

    p_read_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> (word_q == {$past(word_q[MSB-1:0]), $past(word_q[MSB])}));

    p_write_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> (word_q == {$past(word_q[MSB-1:0]), $past(ser_in)}));

    p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(word_q));

endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg
    import recirc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [WIDTH-1:0]  din,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe
);

    op_e  op;
    logic port_oe;
    logic top_bit;

    recirc_op_decode i_decode (
        .sel_n   (sel_n),
        .mode    (mode),
        .op      (op),
        .port_oe (port_oe)
    );

    recirc_shift_core #(.WIDTH(WIDTH)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ser_in  (ser_in),
        .din     (din),
        .top_bit (top_bit)
    );

    // Port outputs: quiet low unless driving
    always_comb begin
        ser_oe  = port_oe;
        ser_out = port_oe ? top_bit : 1'b0;
    end

    p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && mode == MODE_READ) |-> ser_oe);

    p_write_listens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && mode == MODE_WRITE) |-> !ser_oe);

    p_deselect_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (!ser_oe && !ser_out));

    p_quiet_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> (ser_out == 1'b0));

endmodule

// File: tb/test_recirc_shift_reg.sv
module test_recirc_shift_reg;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] din = '0;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic         ser_oe;

    int checks = 0;
    int failures = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    recirc_shift_reg #(.WIDTH(W)) i_recirc_shift_reg (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mode(mode),
        .din(din), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected bit for every driven port cycle
    always @(negedge clk) begin
        if (rst_n && ser_oe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "port driven with nothing expected", W'(ser_oe), '0);
            end else begin
                automatic logic  e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(ser_out === e, t, "serial read bit", W'(ser_out), W'(e));
            end
        end
    end

    task automatic idle_cycle();
        sel_n = 1'b0; mode = 2'b00;
        @(posedge clk); #1;
    endtask

    // Driver: a read of nbits pushes the expected bits, top first
    task automatic read_word(input logic [W-1:0] val, input int nbits, input string tag);
        for (int i = 0; i < nbits; i++) begin
            sel_n = 1'b0; mode = 2'b10;
            exp_q.push_back(val[W-1-i]);
            tag_q.push_back(tag);
            @(posedge clk); #1;
        end
        mode = 2'b00;
        #1;
        check(exp_q.size() == 0, tag, "scoreboard drained", W'(exp_q.size()), '0);
    endtask

    task automatic load_word(input logic [W-1:0] val);
        sel_n = 1'b0; mode = 2'b11; din = val;
        @(posedge clk); #1;
        mode = 2'b00; din = ~val;
    endtask

    task automatic write_bits(input logic [W-1:0] val, input int nbits, input string tag);
        for (int i = 0; i < nbits; i++) begin
            sel_n = 1'b0; mode = 2'b01; ser_in = val[nbits-1-i];
            #1;
            check(!ser_oe && !ser_out, tag, "port idle during write",
                  W'({ser_oe, ser_out}), '0);
            @(posedge clk); #1;
        end
        mode = 2'b00;
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "WDOG", "watchdog expired", '0, '1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!ser_oe && !ser_out, "R8", "port quiet in reset", W'({ser_oe, ser_out}), '0);
        rst_n = 1'b1;
        idle_cycle();

        // R1: reset state reads back as zero
        read_word(16'h0000, W, "R1");

        // R2 then R4: load, read full word twice
        load_word(16'hA5C3);
        read_word(16'hA5C3, W, "R2");
        read_word(16'hA5C3, W, "R4");

        // R3: wrap of the top bit into bit 0
        load_word(16'h8001);
        read_word(16'h8001, 3, "R3");
        read_word(16'h000C, W, "R3");

        // R5: full serial write
        load_word(16'h0000);
        write_bits(16'h3C96, W, "R5");
        read_word(16'h3C96, W, "R5");

        // R6: hold ignores ser_in and din
        for (int i = 0; i < 4; i++) begin
            sel_n = 1'b0; mode = 2'b00; ser_in = i[0]; din = 16'h1111 * i[3:0];
            #1;
            check(!ser_oe && !ser_out, "R6", "port idle in hold", W'({ser_oe, ser_out}), '0);
            @(posedge clk); #1;
        end
        read_word(16'h3C96, W, "R6");

        // R7: deselected, every mode leaves the word alone
        for (int m = 0; m < 4; m++) begin
            sel_n = 1'b1; mode = m[1:0]; ser_in = 1'b1; din = 16'hFFFF;
            #1;
            check(!ser_oe, "R7", "no drive while deselected", W'(ser_oe), '0);
            check(!ser_out, "R8", "output low while disabled", W'(ser_out), '0);
            @(posedge clk); #1;
        end
        sel_n = 1'b0; mode = 2'b00;
        read_word(16'h3C96, W, "R7");

        // R5: partial write into ones
        load_word(16'hFFFF);
        write_bits(16'h0000, 4, "R5");
        read_word(16'hFFF0, W, "R5");

        // R2: further load patterns
        for (int k = 0; k < 4; k++) begin
            automatic logic [W-1:0] v = 16'h1357 ^ (16'h9E37 * (k + 1));
            load_word(v);
            read_word(v, W, "R2");
        end

        // R4: recirculation survives back-to-back loads and reads
        read_word(16'h1357 ^ (16'h9E37 * 4), W, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule